// File: doc/BRIEF.md
# Guarded Rising-Edge Pending Flags

This block keeps one sticky pending flag per event line. A flag goes high when its synchronous event input shows a rising edge between two clock cycles, or when a one-cycle software trigger pulse arrives for that line. Software reads the flag bank through a small register port and acknowledges lines by writing ones to their bit positions. Bits written as zero are left alone.

Every line carries two side-band protection inputs: a secure-only bit and a privileged-only bit. Each read and each write arrives with two attributes, secure and privileged. An access reaches a line only if it passes both checks. A failed read returns zero in that bit position, and a failed write leaves that flag untouched. A parameter mask marks lines that are not built. Such lines hold zero for good and ignore events, triggers and writes.

Top module: `edge_pend_top`

## Requirements
- R1: On the clock edge after an event input rises (its value was 0 at the previous edge and is 1 now), or after a software trigger pulse, the flag of a present line is 1. A level held high does not set the flag again once it has been cleared.
- R2: A write sets a permitted flag to 0 wherever the written data bit is 1. Bits written as 0 keep their value.
- R3: After reset every flag is 0 and the read data word is 0.
- R4: With a line's secure-only bit at 0, both secure and non-secure accesses read and clear that line's flag.
- R5: With a line's secure-only bit at 1, a non-secure read returns 0 in that bit and a non-secure write does not change that flag.
- R6: With a line's privileged-only bit at 1, an unprivileged read returns 0 in that bit and an unprivileged write does not change that flag.
- R7: With a line's privileged-only bit at 0, both privileged and unprivileged accesses read and clear that line's flag.
- R8: A line whose bit in the presence mask is 0 (lines 23, 24 and 25 under the default mask 0x07F_FFFF) always reads 0 and never sets, whatever its event, trigger or write inputs do.
- R9: Read data is a register. On a clock edge with the read strobe high it captures the filtered flags as they stood before that edge, bit i holding line i. Without a strobe it holds its value. Bits 31 down to 26 always read 0.
- R10: If a set cause and a permitted write-one clear hit the same flag in the same cycle, the flag ends at 1.
- R11: The two checks are independent. A secure but unprivileged access, or a privileged but non-secure access, cannot see or clear a line that has both protection bits at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtIn | input | 26 | Synchronous event inputs, one per line |
| swTrig | input | 26 | Software trigger pulses, one per line |
| lineSec | input | 26 | Per-line secure-only configuration |
| linePriv | input | 26 | Per-line privileged-only configuration |
| accSecure | input | 1 | Current access is secure |
| accPriv | input | 1 | Current access is privileged |
| wrEn | input | 1 | Single-cycle write strobe |
| wrData | input | 32 | Write data; a 1 clears the matching flag |
| rdEn | input | 1 | Read strobe that loads the read register |
| rdData | output | 32 | Registered, filtered flag word |

## Verification
The bench targets the cases a flawed block would most likely get wrong. It tests a set and a clear on the same bit in one cycle, where a design that lets the clear win loses the event. It holds an event level high after an acknowledge, where a level-triggered design would set the flag again at once. It issues accesses that pass only one of the two protection checks, where a design that ORs the checks leaks or clears a protected line. It drives events and triggers into absent lines, where a design that only masks the read still keeps live state. A random phase checks every cycle of the read register against a model built from the requirements. That model also exposes reads that return the value after the edge instead of the value before it.

// File: rtl/pend_pkg.sv
package pend_pkg;

  localparam int LINES_DEF = 26;
  localparam int BUS_W_DEF = 32;
  localparam logic [LINES_DEF-1:0] PRESENT_DEF = 26'h07F_FFFF;

  // Strobes handed from the access control to the flag datapath
  typedef struct packed {
    logic clrStb;  // apply the permitted clear mask this cycle
    logic rdStb;   // load the read register this cycle
  } accStrobes_t;

endpackage

// File: rtl/pend_access_ctrl.sv
module pend_access_ctrl
  import pend_pkg::*;
#(
  parameter int LINES = LINES_DEF,
  parameter logic [LINES-1:0] PRESENT = PRESENT_DEF
) (
  input  logic [LINES-1:0] lineSec,
  input  logic [LINES-1:0] linePriv,
  input  logic             accSecure,
  input  logic             accPriv,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [LINES-1:0] wrBits,
  output accStrobes_t      strobes,
  output logic [LINES-1:0] allowMask,
  output logic [LINES-1:0] clrMask
);

  // Per line: both the security and the privilege check must pass
  for (genvar i = 0; i < LINES; i++) begin : g_gate
    logic secOk;
    logic privOk;
    assign secOk  = !lineSec[i] || accSecure;
    assign privOk = !linePriv[i] || accPriv;
    if (PRESENT[i]) begin : g_live
      assign allowMask[i] = secOk && privOk;
    end else begin : g_dead
      logic unusedOk;
      assign unusedOk     = secOk ^ privOk;
      assign allowMask[i] = 1'b0;
    end
  end

  always_comb begin
    strobes.clrStb = wrEn;
    strobes.rdStb  = rdEn;
    clrMask        = wrBits & allowMask;
  end

endmodule

// File: rtl/pend_flag_dp.sv
module pend_flag_dp
  import pend_pkg::*;
#(
  parameter int LINES = LINES_DEF,
  parameter int BUS_W = BUS_W_DEF,
  parameter logic [LINES-1:0] PRESENT = PRESENT_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] evtIn,
  input  logic [LINES-1:0] swTrig,
  input  accStrobes_t      strobes,
  input  logic [LINES-1:0] allowMask,
  input  logic [LINES-1:0] clrMask,
  output logic [LINES-1:0] flagsQ,
  output logic [BUS_W-1:0] rdData
);

  logic [BUS_W-1:0] rdDataQ;
  logic [BUS_W-1:0] rdNext;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    if (PRESENT[i]) begin : g_live
      logic evtPrev;
      logic flagR;
      logic setHit;
      logic clrHit;
      assign setHit = (evtIn[i] && !evtPrev) || swTrig[i];
      assign clrHit = strobes.clrStb && clrMask[i];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          evtPrev <= 1'b0;
          flagR   <= 1'b0;
        end else begin
          evtPrev <= evtIn[i];
          // a set in the same cycle as a clear wins
          flagR   <= setHit || (flagR && !clrHit);
        end
      end
      assign flagsQ[i] = flagR;
    end else begin : g_dead
      logic unusedIn;
      assign unusedIn  = evtIn[i] ^ swTrig[i] ^ clrMask[i];
      assign flagsQ[i] = 1'b0;
    end
  end

  assign rdNext = BUS_W'(flagsQ & allowMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
    end else if (strobes.rdStb) begin
      rdDataQ <= rdNext;
    end
  end

  assign rdData = rdDataQ;

endmodule

// File: rtl/edge_pend_top.sv
module edge_pend_top
  import pend_pkg::*;
#(
  parameter int LINE_CNT = LINES_DEF,
  parameter int BUS_W = BUS_W_DEF,
  parameter logic [LINE_CNT-1:0] PRESENT_MASK = PRESENT_DEF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LINE_CNT-1:0] evtIn,
  input  logic [LINE_CNT-1:0] swTrig,
  input  logic [LINE_CNT-1:0] lineSec,
  input  logic [LINE_CNT-1:0] linePriv,
  input  logic                accSecure,
  input  logic                accPriv,
  input  logic                wrEn,
  input  logic [BUS_W-1:0]    wrData,
  input  logic                rdEn,
  output logic [BUS_W-1:0]    rdData
);

  accStrobes_t         strobes;
  logic [LINE_CNT-1:0] allowMask;
  logic [LINE_CNT-1:0] clrMask;
  logic [LINE_CNT-1:0] flagsQ;

  if (BUS_W > LINE_CNT) begin : g_hi
    logic unusedWrHi;
    assign unusedWrHi = ^wrData[BUS_W-1:LINE_CNT];
  end

  pend_access_ctrl #(
    .LINES  (LINE_CNT),
    .PRESENT(PRESENT_MASK)
  ) ctrl_i (
    .lineSec  (lineSec),
    .linePriv (linePriv),
    .accSecure(accSecure),
    .accPriv  (accPriv),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wrBits   (wrData[LINE_CNT-1:0]),
    .strobes  (strobes),
    .allowMask(allowMask),
    .clrMask  (clrMask)
  );

  pend_flag_dp #(
    .LINES  (LINE_CNT),
    .BUS_W  (BUS_W),
    .PRESENT(PRESENT_MASK)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .evtIn    (evtIn),
    .swTrig   (swTrig),
    .strobes  (strobes),
    .allowMask(allowMask),
    .clrMask  (clrMask),
    .flagsQ   (flagsQ),
    .rdData   (rdData)
  );

endmodule

// File: rtl/edge_pend_chk.sv
module edge_pend_chk #(
  parameter int LINES = 26,
  parameter int BUS_W = 32,
  parameter logic [LINES-1:0] PRESENT = 26'h07F_FFFF
) (
  input logic             clk,
  input logic             rstN,
  input logic [LINES-1:0] swTrig,
  input logic [LINES-1:0] lineSec,
  input logic [LINES-1:0] linePriv,
  input logic             accSecure,
  input logic             accPriv,
  input logic             wrEn,
  input logic [BUS_W-1:0] wrData,
  input logic             rdEn,
  input logic [BUS_W-1:0] rdData,
  input logic [LINES-1:0] flagsQ
);

  for (genvar gi = 0; gi < LINES; gi++) begin : g_bit
    if (PRESENT[gi]) begin : g_live
      // R1
      sw_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
        swTrig[gi] |=> flagsQ[gi]);
      // R2
      hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        flagsQ[gi] && !(wrEn && wrData[gi]) |=> flagsQ[gi]);
      // R5
      nsec_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
        rdEn && lineSec[gi] && !accSecure |=> !rdData[gi]);
      // R5
      nsec_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
        flagsQ[gi] && wrEn && lineSec[gi] && !accSecure |=> flagsQ[gi]);
      // R6
      upriv_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
        rdEn && linePriv[gi] && !accPriv |=> !rdData[gi]);
      // R6
      upriv_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
        flagsQ[gi] && wrEn && linePriv[gi] && !accPriv |=> flagsQ[gi]);
      // R10
      set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
        swTrig[gi] && wrEn && wrData[gi] |=> flagsQ[gi]);
    end else begin : g_dead
      // R8
      absent_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        !flagsQ[gi] && !rdData[gi]);
    end
  end

  if (BUS_W > LINES) begin : g_hi
    // R9
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      rdData[BUS_W-1:LINES] == '0);
  end

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind edge_pend_top edge_pend_chk #(
  .LINES  (LINE_CNT),
  .BUS_W  (BUS_W),
  .PRESENT(PRESENT_MASK)
) chk_i (.*);

// File: tb/edge_pend_top_tb_top.sv
`timescale 1ns/1ps
module edge_pend_top_tb_top;

  localparam int N  = 26;
  localparam int BW = 32;
  localparam logic [N-1:0] PRES = 26'h07F_FFFF;  // lines 23..25 absent

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rstN;
  logic [N-1:0]  evtIn, swTrig, lineSec, linePriv;
  logic          accSecure, accPriv, wrEn, rdEn;
  logic [BW-1:0] wrData, rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0]  mFlags, mPrev;
  logic [BW-1:0] mRd;

  edge_pend_top dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .swTrig(swTrig),
    .lineSec(lineSec), .linePriv(linePriv), .accSecure(accSecure),
    .accPriv(accPriv), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData)
  );

  function automatic logic [N-1:0] allowF(logic [N-1:0] s, logic [N-1:0] p,
                                          logic as, logic ap);
    return PRES & (~s | {N{as}}) & (~p | {N{ap}});
  endfunction

  task automatic check(string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdData=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: model update, then compare at the falling edge
  task automatic tick();
    logic [N-1:0]  setV, clrV, nxt;
    logic [BW-1:0] rdN;
    setV = PRES & ((evtIn & ~mPrev) | swTrig);
    clrV = wrEn ? (wrData[N-1:0] & allowF(lineSec, linePriv, accSecure, accPriv)) : '0;
    nxt  = (mFlags & ~clrV) | setV;
    rdN  = rdEn ? BW'(mFlags & allowF(lineSec, linePriv, accSecure, accPriv)) : mRd;
    @(posedge clk);
    @(negedge clk);
    mFlags = nxt;
    mPrev  = evtIn;
    mRd    = rdN;
    check("R9 model", rdData, mRd);
    swTrig = '0;
    wrEn   = 1'b0;
    rdEn   = 1'b0;
  endtask

  task automatic rd(logic as, logic ap, string tag, logic [BW-1:0] exp);
    accSecure = as; accPriv = ap; rdEn = 1'b1;
    tick();
    check(tag, rdData, exp);
  endtask

  task automatic wr(logic [BW-1:0] d, logic as, logic ap);
    accSecure = as; accPriv = ap; wrEn = 1'b1; wrData = d;
    tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run hung");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; evtIn = '0; swTrig = '0; lineSec = '0; linePriv = '0;
    accSecure = 1'b1; accPriv = 1'b1; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    mFlags = '0; mPrev = '0; mRd = '0;
    repeat (4) @(negedge clk);
    check("R3 reset rdData", rdData, '0);
    rstN = 1'b1;
    tick();
    rd(1, 1, "R3 flags after reset", 32'h0);

    // R1: software trigger and rising edge
    swTrig = N'(1) << 3; tick();
    rd(1, 1, "R1 trigger", 32'h0000_0008);
    evtIn[5] = 1'b1; tick();
    rd(1, 1, "R1 rising edge", 32'h0000_0028);
    wr(32'h20, 1, 1);
    tick(); tick();
    rd(1, 1, "R1 held level no re-set", 32'h0000_0008);

    // R2: zero write keeps, one write clears
    wr(32'h0, 1, 1);
    rd(1, 1, "R2 zero write", 32'h0000_0008);
    wr(32'h8, 1, 1);
    rd(1, 1, "R2 one write", 32'h0);

    // R5 / R4: secure-only bit
    swTrig = N'(1) << 3; tick();
    lineSec[3] = 1'b1;
    rd(0, 1, "R5 non-secure read", 32'h0);
    wr(32'h8, 0, 1);
    rd(1, 1, "R5 non-secure write dropped", 32'h0000_0008);
    lineSec[3] = 1'b0;
    rd(0, 1, "R4 non-secure read open", 32'h0000_0008);
    wr(32'h8, 0, 1);
    rd(1, 1, "R4 non-secure clear open", 32'h0);

    // R6 / R7: privileged-only bit
    swTrig = N'(1) << 7; tick();
    linePriv[7] = 1'b1;
    rd(1, 0, "R6 unprivileged read", 32'h0);
    wr(32'h80, 1, 0);
    rd(1, 1, "R6 unprivileged write dropped", 32'h0000_0080);
    linePriv[7] = 1'b0;
    rd(1, 0, "R7 unprivileged read open", 32'h0000_0080);
    wr(32'h80, 1, 0);
    rd(1, 1, "R7 unprivileged clear open", 32'h0);

    // R11: both protections, partial attributes
    swTrig = N'(1) << 10; tick();
    lineSec[10] = 1'b1; linePriv[10] = 1'b1;
    rd(1, 0, "R11 secure unprivileged read", 32'h0);
    rd(0, 1, "R11 privileged non-secure read", 32'h0);
    wr(32'h400, 1, 0);
    wr(32'h400, 0, 1);
    rd(1, 1, "R11 partial writes dropped", 32'h0000_0400);
    wr(32'h400, 1, 1);
    rd(1, 1, "R11 full access clears", 32'h0);
    lineSec = '0; linePriv = '0;

    // R8: absent lines
    evtIn[5] = 1'b0; evtIn[23] = 1'b1; swTrig = (N'(1) << 24) | (N'(1) << 25);
    tick();
    rd(1, 1, "R8 absent lines", 32'h0);
    evtIn[23] = 1'b0;

    // R10: set and clear collide
    swTrig = N'(1) << 12; wrEn = 1'b1; wrData = 32'h1000; tick();
    rd(1, 1, "R10 set wins", 32'h0000_1000);
    wr(32'hFFFF_FFFF, 1, 1);

    // R9: hold without strobe, upper bits zero
    swTrig = N'(1) << 22; tick();
    rd(1, 1, "R9 capture", 32'h0040_0000);
    swTrig = N'(1) << 1; tick(); tick();
    check("R9 hold", rdData, 32'h0040_0000);
    wr(32'hFFFF_FFFF, 1, 1);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      evtIn     = N'($urandom);
      swTrig    = N'($urandom & $urandom & $urandom);
      if (($urandom % 16) == 0) lineSec  = N'($urandom);
      if (($urandom % 16) == 0) linePriv = N'($urandom);
      accSecure = 1'($urandom);
      accPriv   = 1'($urandom);
      wrEn      = (($urandom % 4) == 0);
      wrData    = $urandom;
      rdEn      = 1'($urandom);
      tick();
    end

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule